// File: doc/BRIEF.md
# Addressable Bit Latch Bank with One-Hot Demultiplexer

The block holds a small bank of single-bit storage cells, eight with the default three-bit address. Each cell drives its own parallel output. A single data bit, an address and two active-low controls are sampled on every rising clock edge. The two controls together choose one of four modes. Write mode updates only the addressed cell. Hold mode freezes the bank. Demultiplexer mode drives the data bit onto the addressed cell and zero onto every other cell. Clear mode zeroes the whole bank.

A typical use is serial-to-parallel conversion: a host steps the address through every value in write mode and presents one bit per step, then reads the whole word from the parallel outputs. With the data bit held high, demultiplexer mode turns the bank into an active-high binary-to-one-hot decoder. The decoded pattern is stored, so it remains after the controls return to hold. A separate asynchronous active-low power-on reset, released synchronously inside the block, zeroes every cell.

Top module: `addr_latch`

## Requirements
- R1: With write enable low and clear high (write mode), at the next rising edge the output selected by the address takes the data value and every other output keeps its previous value.
- R2: With write enable high and clear high (hold mode), every output keeps its value whatever the address and data inputs are.
- R3: With write enable low and clear low (demultiplexer mode), at the next rising edge the addressed output takes the data value and every other output becomes 0.
- R4: With write enable high and clear low (clear mode), at the next rising edge every output becomes 0 whatever the address and data inputs are.
- R5: The address is an unsigned binary number with bit 0 as its least significant bit, and value n selects output bit q[n]. Stepping the address from 0 to 7 in write mode loads a serial stream so that stream bit i appears on q[i].
- R6: In demultiplexer mode with data high, the outputs form the one-hot code 1 << address, and that code persists unchanged through following hold-mode cycles.
- R7: While the power-on reset rst_n is low, all outputs are 0 at once, without waiting for a clock edge.
- R8: The outputs are registered: a change on the control, address or data inputs between rising edges does not alter the outputs until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low power-on reset, released synchronously |
| wr_n | input | 1 | Active-low write enable |
| clr_n | input | 1 | Active-low conditional clear; with wr_n low it selects demultiplexer mode |
| sel | input | ADDR_W (3) | Binary address of the target bit, bit 0 least significant |
| din | input | 1 | Data bit |
| q | output | 2**ADDR_W (8) | Parallel outputs of the storage cells |

## Verification
The assertions assume that the control, address and data inputs are stable and known at each rising edge once the internal reset has been released. They also assume that power-on reset is the only thing that changes the bank outside a clock edge. The stimulus changes every input on the falling edge and leaves the inputs in hold mode while reset is asserted. It pulses the power-on reset only between edges. This keeps each sampled input vector well defined for the property checks.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

  typedef enum logic [1:0] {
    MODE_CLEAR = 2'b00,
    MODE_DEMUX = 2'b01,
    MODE_HOLD  = 2'b10,
    MODE_WRITE = 2'b11
  } bank_mode_e;

endpackage

// File: rtl/addr_latch_rst_sync.sv
module addr_latch_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/addr_latch_mode_dec.sv
module addr_latch_mode_dec
  import addr_latch_pkg::*;
(
  input  logic       wr_n,
  input  logic       clr_n,
  output bank_mode_e mode
);

  always_comb begin
    unique case ({wr_n, clr_n})
      2'b01:   mode = MODE_WRITE;
      2'b11:   mode = MODE_HOLD;
      2'b00:   mode = MODE_DEMUX;
      default: mode = MODE_CLEAR;
    endcase
  end

endmodule

// File: rtl/addr_latch_onehot.sv
module addr_latch_onehot #(
  parameter int ADDR_W = 3,
  localparam int NBITS = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] sel,
  output logic [NBITS-1:0]  hit
);

  for (genvar i = 0; i < NBITS; i++) begin : g_hit
    assign hit[i] = (sel == ADDR_W'(i));
  end

endmodule

// File: rtl/addr_latch_cell.sv
module addr_latch_cell
  import addr_latch_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  bank_mode_e mode,
  input  logic       hit,
  input  logic       din,
  output logic       q
);

  logic d_next;
  logic ce;

  always_comb begin
    ce     = 1'b0;
    d_next = q;
    unique case (mode)
      MODE_WRITE: begin
        ce     = hit;
        d_next = din;
      end
      MODE_DEMUX: begin
        ce     = 1'b1;
        d_next = hit & din;
      end
      MODE_CLEAR: begin
        ce     = 1'b1;
        d_next = 1'b0;
      end
      default: begin
        ce     = 1'b0;
        d_next = q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else if (ce) begin
      q <= d_next;
    end
  end

endmodule

// File: rtl/addr_latch.sv
module addr_latch
  import addr_latch_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int NBITS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic              clr_n,
  input  logic [ADDR_W-1:0] sel,
  input  logic              din,
  output logic [NBITS-1:0]  q
);

  logic       rst_sync_n;
  bank_mode_e mode;
  logic [NBITS-1:0] hit;

  addr_latch_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  addr_latch_mode_dec u_mode (
    .wr_n  (wr_n),
    .clr_n (clr_n),
    .mode  (mode)
  );

  addr_latch_onehot #(.ADDR_W(ADDR_W)) u_dec (
    .sel (sel),
    .hit (hit)
  );

  for (genvar i = 0; i < NBITS; i++) begin : g_cell
    addr_latch_cell u_cell (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .mode  (mode),
      .hit   (hit[i]),
      .din   (din),
      .q     (q[i])
    );
  end

  // R1: addressed bit written, every other bit unchanged
  a_r1_write_target: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!wr_n && clr_n) |=> (q[$past(sel)] == $past(din)));
  a_r1_write_others: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!wr_n && clr_n) |=>
      (((q ^ $past(q)) & ~(NBITS'(1) << $past(sel))) == '0));

  // R2: hold mode freezes the bank
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_n && clr_n) |=> $stable(q));

  // R3: demultiplexer mode leaves at most the addressed bit set
  a_r3_demux: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!wr_n && !clr_n) |=>
      ($countones(q) <= 1) && (q[$past(sel)] == $past(din)));

  // R4: clear mode empties the bank
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_n && !clr_n) |=> (q == '0));

  // R6: decoder with data high yields a one-hot word
  a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!wr_n && !clr_n && din) |=> $onehot0(q) && (q != '0));

endmodule

// File: tb/tb_addr_latch.sv
module tb_addr_latch;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 3;
  localparam int NBITS      = 1 << ADDR_W;

  logic              clk;
  logic              rst_n;
  logic              wr_n;
  logic              clr_n;
  logic [ADDR_W-1:0] sel;
  logic              din;
  logic [NBITS-1:0]  q;

  int n_vec;
  int n_bad;
  logic [NBITS-1:0] model;

  addr_latch #(.ADDR_W(ADDR_W)) dut (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_n  (wr_n),
    .clr_n (clr_n),
    .sel   (sel),
    .din   (din),
    .q     (q)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input logic [NBITS-1:0] act,
                       input logic [NBITS-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: q=%b expected %b", tag, act, exp);
    end
  endtask

  // Expected next word, from the mode table in the requirements
  function automatic logic [NBITS-1:0] predict(input logic [NBITS-1:0] cur,
      input logic w, input logic c, input int a, input logic d);
    logic [NBITS-1:0] bitm;
    bitm = NBITS'(1) << a;
    if (!w && c)       return d ? (cur | bitm) : (cur & ~bitm);
    else if (w && c)   return cur;
    else if (!w && !c) return d ? bitm : '0;
    else               return '0;
  endfunction

  task automatic step(input string tag, input logic w, input logic c,
                      input int a, input logic d);
    @(negedge clk);
    wr_n = w; clr_n = c; sel = ADDR_W'(a); din = d;
    @(posedge clk);
    #1;
    model = predict(model, w, c, a, d);
    check(tag, q, model);
  endtask

  task automatic load(input logic [NBITS-1:0] pat);
    for (int i = 0; i < NBITS; i++) step("R1", 1'b0, 1'b1, i, pat[i]);
  endtask

  initial begin
    n_vec = 0; n_bad = 0; model = '0;
    wr_n = 1'b1; clr_n = 1'b1; sel = '0; din = 1'b0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    #2 check("R7", q, '0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R7", q, '0);

    // R5: serial stream loaded bit i at address i
    begin
      logic [NBITS-1:0] stream;
      stream = 8'b1011_0010;
      load(stream);
      check("R5", q, stream);
    end

    // R2: hold ignores every address and data value
    for (int a = 0; a < NBITS; a++)
      for (int d = 0; d < 2; d++) step("R2", 1'b1, 1'b1, a, d[0]);

    // R6: decoder sweep, then persistence in hold
    for (int a = 0; a < NBITS; a++) begin
      step("R6", 1'b0, 1'b0, a, 1'b1);
      check("R6", q, NBITS'(1) << a);
      step("R6", 1'b1, 1'b1, (a + 3) % NBITS, 1'b0);
      step("R6", 1'b1, 1'b1, (a + 5) % NBITS, 1'b1);
    end

    // R3: demultiplexer with data low empties the bank
    load(8'hFF);
    step("R3", 1'b0, 1'b0, 4, 1'b0);
    check("R3", q, '0);

    // Exhaustive mode x address x data from several starting words
    for (int p = 0; p < 4; p++) begin
      for (int m = 0; m < 4; m++) begin
        for (int a = 0; a < NBITS; a++) begin
          for (int d = 0; d < 2; d++) begin
            logic [NBITS-1:0] pat;
            logic w, c;
            string tg;
            pat = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF :
                  (p == 2) ? 8'hA5 : 8'h3C;
            w = m[1]; c = m[0];
            tg = (!w && c) ? "R1" : (w && c) ? "R2" :
                 (!w && !c) ? "R3" : "R4";
            load(pat);
            step(tg, w, c, a, d[0]);
          end
        end
      end
    end

    // R8: inputs changed between edges do not reach the outputs early
    load(8'h5A);
    @(negedge clk);
    wr_n = 1'b1; clr_n = 1'b0; sel = '0; din = 1'b1;
    #1 check("R8", q, 8'h5A);
    @(posedge clk);
    #1 model = '0;
    check("R8", q, '0);

    // R7: asynchronous power-on reset mid-cycle
    load(8'hC3);
    @(negedge clk);
    wr_n = 1'b1; clr_n = 1'b1;
    #2 rst_n = 1'b0;
    #1 check("R7", q, '0);
    @(negedge clk) rst_n = 1'b1;
    model = '0;
    repeat (3) @(posedge clk);
    #1 check("R7", q, '0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: q=%b expected completion", q);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule